// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block sits on the host side of an asynchronous parallel EEPROM. It drives the address, data, chip-enable, output-enable and write-enable pins so that a group of bytes in the same page is loaded and then committed by the memory's internal write. Bytes come in on a valid/ready stream. Each beat carries an address, a data byte and a last flag. Every accepted byte becomes one write-enable low pulse. The pulse is long enough for the pulse-width minimum, the data-setup minimum and the address-hold minimum.

Successive pulses are spaced so that the gap between two write-enable rising edges stays inside the memory's byte-load window. A page closes in three ways: the last flag is seen, the window runs out, or a byte from a different page arrives. After a page closes, the controller locks out all writes for the internal write-cycle time. It also keeps writes off for an inhibit period after reset. Every delay is given in nanoseconds and turned into clock cycles from a clock-period parameter. Minimum times are rounded up and maximum times are rounded down.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset is released, `in_ready` stays low and `mem_we_n` stays high for exactly N_INIT cycles, where N_INIT = ceil(T_INIT_NS / clock period). `busy` is high throughout that period.
- R2: The clock edge that completes a handshake (`in_valid` and `in_ready` both high) drives `mem_we_n` and `mem_ce_n` low. On that same edge, `mem_addr` and `mem_data` take the beat's address and data.
- R3: Each write-enable low pulse lasts exactly N_PULSE cycles. N_PULSE is the largest of ceil(T_WP_NS), ceil(T_DS_NS) and ceil(T_AH_NS), each converted to cycles.
- R4: `mem_addr` and `mem_data` do not change while `mem_we_n` is low.
- R5: `mem_oe_n` is high at all times, and in particular around every write-enable pulse.
- R6: `in_ready` is low whenever `mem_we_n` is low.
- R7: Two successive write-enable rising edges are at least ceil(T_BLCMIN_NS) cycles apart.
- R8: If no byte of the same page is accepted after a rising edge, the page closes. `in_ready` falls floor(T_BLCMAX_NS) − N_PULSE cycles after that edge. The lockout of R9 then follows, so rise-to-rise spacing inside a page never exceeds floor(T_BLCMAX_NS) cycles.
- R9: After the rising edge of a byte that carried the last flag, `in_ready` stays low for exactly N_WC = ceil(T_WC_NS) cycles and no write pulse is issued.
- R10: The page tag of an address is bits [ADDR_W-1:PAGE_BITS]. While a page is open, a valid beat whose tag differs from the open page is not accepted. That beat closes the page on the next clock edge and is accepted only after the N_WC lockout. `in_ready` therefore returns N_WC+1 cycles after the last rising edge.
- R11: `busy` is low only while the controller is idle and able to start a new page. It is high during the inhibit period, during byte loads, between byte loads of an open page, and during the lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat accepted when high with in_valid |
| in_addr | input | ADDR_W | Byte address of the beat |
| in_data | input | DATA_W | Byte to write |
| in_last | input | 1 | Beat is the final byte of its page |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_data | output | DATA_W | Memory data pins (write direction only) |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low (held high) |
| mem_we_n | output | 1 | Memory write enable, active low |
| busy | output | 1 | High whenever the controller is not idle |

## Verification
Pins change one clock edge after the handshake, and the bench samples them at the following falling edge. It then counts falling edges while `mem_we_n` stays low, which gives the pulse length in cycles. The rising-edge cycle of each pulse is stored. The window timeout, the last-byte lockout and the page-mismatch lockout are each measured as the number of edges from that rising edge until `in_ready` changes. The expected values are floor(max)−N_PULSE, N_WC and N_WC+1. Each count is computed from the timing parameters alone, so a pulse or lockout that is off by a single cycle fails its check.

// File: rtl/eepw_pkg.sv
`timescale 1ns/1ps
// eepw_pkg: shared state type and nanosecond-to-cycle conversion helpers.
// Assumes times in ns and clock period in ps, both positive.
package eepw_pkg;

    typedef enum logic [2:0] {
        ST_INHIBIT,
        ST_IDLE,
        ST_PULSE,
        ST_GAP,
        ST_COMMIT
    } wr_state_e;

    // Smallest cycle count whose duration is at least ns
    function automatic int cycles_ceil(input int unsigned ns, input int unsigned ps);
        longint unsigned num;
        num = longint'(ns) * 1000 + longint'(ps) - 1;
        return int'(num / longint'(ps));
    endfunction

    // Largest cycle count whose duration is at most ns
    function automatic int cycles_floor(input int unsigned ns, input int unsigned ps);
        return int'((longint'(ns) * 1000) / longint'(ps));
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/eepw_elapsed.sv
`timescale 1ns/1ps
// eepw_elapsed: saturating up-counter of cycles spent in the current phase.
// Assumes restart is pulsed on the edge that enters a new phase.
module eepw_elapsed #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);

    // Count up from zero after each restart, holding at the top value
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (count != '1) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/eepw_page_track.sv
`timescale 1ns/1ps
// eepw_page_track: remembers the page tag of the last loaded byte and
// compares an incoming tag against it. Assumes the caller slices the tags.
module eepw_page_track #(
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TAG_W-1:0] load_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);

    logic [TAG_W-1:0] open_tag;

    // Capture the tag of every byte that starts a write pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_tag <= '0;
        end else if (load) begin
            open_tag <= load_tag;
        end
    end

    // Same-page test for the beat currently offered on the stream
    always_comb begin
        hit = (probe_tag == open_tag);
    end

endmodule

// File: rtl/eeprom_page_writer.sv
`timescale 1ns/1ps
// eeprom_page_writer: turns a byte stream into write-enable pulses for an
// asynchronous parallel EEPROM, groups them into pages, spaces them inside
// the byte-load window and locks out writes for the internal write cycle
// and for an inhibit period after reset.
// Assumes: parameters satisfy floor(T_BLCMAX) > N_PULSE + GAP_MIN, and the
// memory is only written (output enable is parked high).
module eeprom_page_writer #(
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned PAGE_BITS     = 7,
    parameter int unsigned T_WP_NS       = 100,
    parameter int unsigned T_DS_NS       = 50,
    parameter int unsigned T_AH_NS       = 50,
    parameter int unsigned T_BLCMIN_NS   = 100,
    parameter int unsigned T_BLCMAX_NS   = 100000,
    parameter int unsigned T_WC_NS       = 5000000,
    parameter int unsigned T_INIT_NS     = 5000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              busy
);
    import eepw_pkg::*;

    localparam int N_PULSE_RAW = max3(cycles_ceil(T_WP_NS, CLK_PERIOD_PS),
                                      cycles_ceil(T_DS_NS, CLK_PERIOD_PS),
                                      cycles_ceil(T_AH_NS, CLK_PERIOD_PS));
    localparam int N_PULSE  = (N_PULSE_RAW < 1) ? 1 : N_PULSE_RAW;
    localparam int N_BLCMIN = cycles_ceil(T_BLCMIN_NS, CLK_PERIOD_PS);
    localparam int N_BLCMAX = cycles_floor(T_BLCMAX_NS, CLK_PERIOD_PS);
    localparam int N_WC     = cycles_ceil(T_WC_NS, CLK_PERIOD_PS);
    localparam int N_INIT_R = cycles_ceil(T_INIT_NS, CLK_PERIOD_PS);
    localparam int N_INIT   = (N_INIT_R < 1) ? 1 : N_INIT_R;
    // Rise-to-rise spacing is gap_elapsed + 1 + N_PULSE
    localparam int GAP_MIN  = (N_BLCMIN > N_PULSE + 1) ? N_BLCMIN - N_PULSE - 1 : 0;
    localparam int GAP_LAST = N_BLCMAX - N_PULSE - 1;
    localparam int CNT_TOP  = max3(N_INIT, max3(N_WC, N_BLCMAX, N_PULSE), 1);
    localparam int CNT_W    = $clog2(CNT_TOP + 1);
    localparam int TAG_W    = ADDR_W - PAGE_BITS;

    wr_state_e        state, state_d;
    logic             restart;
    logic [CNT_W-1:0] elapsed;
    logic             page_hit;
    logic             last_q;
    logic             accept;
    logic             gap_open;

    eepw_elapsed #(.W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (elapsed)
    );

    eepw_page_track #(.TAG_W(TAG_W)) page_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_tag  (in_addr[ADDR_W-1:PAGE_BITS]),
        .probe_tag (in_addr[ADDR_W-1:PAGE_BITS]),
        .hit       (page_hit)
    );

    // Stream ready: any beat when idle, only same-page beats inside the window
    always_comb begin
        gap_open = (elapsed >= CNT_W'(GAP_MIN));
        in_ready = 1'b0;
        case (state)
            ST_IDLE: in_ready = 1'b1;
            ST_GAP:  in_ready = gap_open && page_hit;
            default: in_ready = 1'b0;
        endcase
        accept = in_valid && in_ready;
    end

    // Phase sequencing and restart of the phase timer
    always_comb begin
        state_d = state;
        restart = 1'b0;
        case (state)
            ST_INHIBIT: if (elapsed == CNT_W'(N_INIT - 1)) begin
                state_d = ST_IDLE;
                restart = 1'b1;
            end
            ST_IDLE: if (accept) begin
                state_d = ST_PULSE;
                restart = 1'b1;
            end
            ST_PULSE: if (elapsed == CNT_W'(N_PULSE - 1)) begin
                state_d = last_q ? ST_COMMIT : ST_GAP;
                restart = 1'b1;
            end
            ST_GAP: begin
                if (accept) begin
                    state_d = ST_PULSE;
                    restart = 1'b1;
                end else if ((elapsed == CNT_W'(GAP_LAST)) ||
                             (in_valid && gap_open && !page_hit)) begin
                    state_d = ST_COMMIT;
                    restart = 1'b1;
                end
            end
            ST_COMMIT: if (elapsed == CNT_W'(N_WC - 1)) begin
                state_d = ST_IDLE;
                restart = 1'b1;
            end
            default: begin
                state_d = ST_INHIBIT;
                restart = 1'b1;
            end
        endcase
    end

    // State register and registered memory pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_INHIBIT;
            mem_we_n <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_addr <= '0;
            mem_data <= '0;
            last_q   <= 1'b0;
        end else begin
            state    <= state_d;
            mem_we_n <= (state_d != ST_PULSE);
            mem_ce_n <= (state_d != ST_PULSE);
            if (accept) begin
                mem_addr <= in_addr;
                mem_data <= in_data;
                last_q   <= in_last;
            end
        end
    end

    // Output enable is parked inactive; busy covers every non-idle phase
    always_comb begin
        mem_oe_n = 1'b1;
        busy     = (state != ST_IDLE);
    end

endmodule

// File: rtl/eepw_checker.sv
`timescale 1ns/1ps
// eepw_checker: timing properties of the memory pins and the stream,
// attached to eeprom_page_writer through bind. Assumes N_* are the same
// cycle counts the controller derives.
module eepw_checker #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int N_PULSE  = 1,
    parameter int N_BLCMIN = 1,
    parameter int N_INIT   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we_n,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              in_ready,
    input logic              busy
);
    localparam int LW = $clog2(N_PULSE + 2);
    localparam int RW = $clog2(N_BLCMIN + 2);
    localparam int IW = $clog2(N_INIT + 2);

    logic [LW-1:0] low_cnt;
    logic [RW-1:0] since_rise;
    logic [IW-1:0] since_rst;
    logic          we_prev;
    logic          seen_rise;

    // Track pulse length, rise-to-rise distance and time since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt    <= '0;
            since_rise <= '0;
            since_rst  <= '0;
            we_prev    <= 1'b1;
            seen_rise  <= 1'b0;
        end else begin
            we_prev <= mem_we_n;
            if (!mem_we_n) begin
                if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
            if (mem_we_n && !we_prev) begin
                since_rise <= RW'(1);
                seen_rise  <= 1'b1;
            end else if (since_rise < RW'(N_BLCMIN)) begin
                since_rise <= since_rise + 1'b1;
            end
            if (since_rst < IW'(N_INIT)) since_rst <= since_rst + 1'b1;
        end
    end

    a_r1_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < IW'(N_INIT)) |-> (!in_ready && mem_we_n && busy));
    a_r2_ce_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);
    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && !we_prev) |-> (low_cnt == LW'(N_PULSE)));
    a_r4_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !we_prev) |-> ($stable(mem_addr) && $stable(mem_data)));
    a_r5_oe_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    a_r6_no_ready_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !in_ready);
    a_r7_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && !we_prev && seen_rise) |-> (since_rise >= RW'(N_BLCMIN)));
    a_r11_busy_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> busy);

endmodule

bind eeprom_page_writer eepw_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .N_PULSE  (N_PULSE),
    .N_BLCMIN (N_BLCMIN),
    .N_INIT   (N_INIT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we_n (mem_we_n),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .in_ready (in_ready),
    .busy     (busy)
);

// File: tb/eeprom_page_writer_tb_top.sv
`timescale 1ns/1ps
// Bench for eeprom_page_writer: table-driven page load, then directed
// tests for window timeout, page mismatch and reset mid-pulse.
module eeprom_page_writer_tb_top;

    localparam int CLK_PS   = 8000;
    localparam int N_PULSE  = 13;   // ceil(100ns/8ns)
    localparam int N_BLCMIN = 13;   // ceil(100ns/8ns)
    localparam int N_BLCMAX = 125;  // floor(1000ns/8ns)
    localparam int N_WC     = 250;  // ceil(2000ns/8ns)
    localparam int N_INIT   = 125;  // ceil(1000ns/8ns)
    localparam int WD_LIMIT = 150000;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        last;
    } vec_t;

    // Same page: tag = addr[15:6] = 5 for all entries
    localparam vec_t PAGE_TBL [4] = '{
        '{addr: 16'h0140, data: 8'hA5, last: 1'b0},
        '{addr: 16'h0141, data: 8'h3C, last: 1'b0},
        '{addr: 16'h0147, data: 8'hFF, last: 1'b0},
        '{addr: 16'h017F, data: 8'h00, last: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addr = '0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        mem_ce_n, mem_oe_n, mem_we_n, busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rise_cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eeprom_page_writer #(
        .CLK_PERIOD_PS (CLK_PS), .ADDR_W (16), .DATA_W (8), .PAGE_BITS (6),
        .T_WP_NS (100), .T_DS_NS (50), .T_AH_NS (50),
        .T_BLCMIN_NS (100), .T_BLCMAX_NS (1000),
        .T_WC_NS (2000), .T_INIT_NS (1000)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_addr (in_addr), .in_data (in_data), .in_last (in_last),
        .mem_addr (mem_addr), .mem_data (mem_data),
        .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n),
        .busy (busy)
    );

    task automatic chk_eq(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count edges until in_ready equals want; note any write pulse seen
    task automatic wait_ready(input logic want, output int n, output logic saw_we);
        n = 0;
        saw_we = 1'b0;
        while (in_ready !== want && n < 100000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!mem_we_n) saw_we = 1'b1;
        end
    endtask

    // Offer one beat, check its pulse, return with time at negedge after rise
    task automatic load_byte(input logic [15:0] a, input logic [7:0] d, input logic l);
        int lowc;
        @(negedge clk);
        in_addr = a; in_data = d; in_last = l; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk_eq("R2 we_n low after handshake", mem_we_n, 0);
        chk_eq("R2 ce_n low after handshake", mem_ce_n, 0);
        chk_eq("R2 address presented", mem_addr, a);
        chk_eq("R2 data presented", mem_data, d);
        chk_eq("R6 ready low in pulse", in_ready, 0);
        chk_eq("R11 busy in pulse", busy, 1);
        lowc = 0;
        while (!mem_we_n && lowc < 1000) begin
            lowc++;
            if (mem_addr !== a || mem_data !== d || mem_oe_n !== 1'b1) begin
                chk_eq("R4 R5 pins steady in pulse", {mem_oe_n, mem_addr, mem_data}, {1'b1, a, d});
            end
            @(negedge clk);
        end
        chk_eq("R3 pulse length", lowc, N_PULSE);
        chk_eq("R5 oe_n high", mem_oe_n, 1);
        rise_cyc = cyc;
    endtask

    initial begin
        int n;
        logic saw;
        int prev_rise;

        // Reset state
        repeat (3) @(negedge clk);
        chk_eq("R1 we_n high in reset", mem_we_n, 1);
        chk_eq("R1 ce_n high in reset", mem_ce_n, 1);
        chk_eq("R5 oe_n high in reset", mem_oe_n, 1);
        chk_eq("R1 ready low in reset", in_ready, 0);
        chk_eq("R11 busy in reset", busy, 1);
        rst_n = 1'b1;
        in_valid = 1'b1;
        in_addr = 16'h0140;
        wait_ready(1'b1, n, saw);
        chk_eq("R1 inhibit length", n, N_INIT);
        chk_eq("R1 no pulse during inhibit", saw, 0);
        in_valid = 1'b0;
        @(negedge clk);
        chk_eq("R11 busy low when idle", busy, 0);

        // Table-driven page load
        prev_rise = 0;
        for (int i = 0; i < 4; i++) begin
            load_byte(PAGE_TBL[i].addr, PAGE_TBL[i].data, PAGE_TBL[i].last);
            if (i > 0) begin
                chk_eq("R7 spacing not below minimum", (rise_cyc - prev_rise) >= N_BLCMIN, 1);
                chk_eq("R8 spacing within maximum", (rise_cyc - prev_rise) <= N_BLCMAX, 1);
            end
            prev_rise = rise_cyc;
        end
        chk_eq("R9 ready low after last", in_ready, 0);
        chk_eq("R11 busy during lockout", busy, 1);
        wait_ready(1'b1, n, saw);
        chk_eq("R9 lockout after last", n, N_WC);
        chk_eq("R9 no pulse in lockout", saw, 0);
        chk_eq("R11 busy low after lockout", busy, 0);

        // Window timeout: single byte, no follow-up
        load_byte(16'h0200, 8'h11, 1'b0);
        in_addr = 16'h0201;
        wait_ready(1'b0, n, saw);
        chk_eq("R8 window closes", n, N_BLCMAX - N_PULSE);
        chk_eq("R11 busy after window close", busy, 1);
        wait_ready(1'b1, n, saw);
        chk_eq("R8 lockout after timeout", n, N_WC);
        chk_eq("R8 no pulse after timeout", saw, 0);

        // Page mismatch closes the page, beat waits for the lockout
        load_byte(16'h0300, 8'h22, 1'b0);
        in_addr = 16'h0400; in_data = 8'h5A; in_last = 1'b1; in_valid = 1'b1;
        #1;
        chk_eq("R10 other page not ready", in_ready, 0);
        wait_ready(1'b1, n, saw);
        chk_eq("R10 mismatch lockout", n, N_WC + 1);
        chk_eq("R10 beat held back", saw, 0);
        load_byte(16'h0400, 8'h5A, 1'b1);
        wait_ready(1'b1, n, saw);
        chk_eq("R9 lockout after mismatched page", n, N_WC);

        // Reset in the middle of a pulse
        @(negedge clk);
        in_addr = 16'h0500; in_data = 8'h77; in_last = 1'b0; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk_eq("R2 pulse started", mem_we_n, 0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_eq("R1 reset ends pulse", mem_we_n, 1);
        rst_n = 1'b1;
        wait_ready(1'b1, n, saw);
        chk_eq("R1 inhibit after second reset", n, N_INIT);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule